// File: doc/BRIEF.md
# String I/O Transfer Sequencer

This block moves a run of elements between an I/O port and memory, one element at a time. A command gives the direction, the element size (1, 2 or 4 bytes), the address width (16 or 32 bits), a flags word, a port register, a pointer, a count and a repeat option. In port-to-memory mode (`dir_out_i` low), each element is read from the port and then written to memory at the pointer. In memory-to-port mode (`dir_out_i` high), each element is read from memory at the pointer and then written to the port.

After each element the pointer moves by the element size. Bit 10 of the flags word chooses the direction: clear means the pointer goes up, set means it goes down. With repeat off, exactly one element is transferred. With repeat on, the count drops by one per element and the run stops when the count reaches zero. Every access is a request held until the matching acknowledge arrives.

When the run ends, `done_o` pulses for one cycle. The updated pointer and count are then available on `ptr_o` and `count_o`.

Top module: `strio_seq`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and neither `mem_req_o` nor `io_req_o` is asserted; no request is ever raised while `busy_o` is low.
- R2: With `dir_out_i`=0, each element is one port read (`io_we_o`=0) followed by one memory write (`mem_we_o`=1) at the pointer, carrying the word captured from `io_rdata_i`. The two requests are never high together.
- R3: With `dir_out_i`=1, each element is one memory read at the pointer followed by one port write carrying the word captured from `mem_rdata_i`.
- R4: `size_i` codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, and `xfer_size_o` repeats the code. When `flags_i[10]`=0 the pointer moves by +size after each element; when it is 1 the pointer moves by −size.
- R5: `io_addr_o` equals the IO_BASE parameter plus the zero-extended low 16 bits of `port_reg_i`.
- R6: With `rep_i`=0, exactly one element is transferred and `count_o` keeps the value given at start.
- R7: With `rep_i`=1, the count drops by one per element, and elements keep being transferred until the count reaches zero.
- R8: With `rep_i`=1 and a count whose low 16 bits (when `wide_addr_i`=0) or low 32 bits (when `wide_addr_i`=1) are zero, there is no access. `done_o` rises in the cycle after start, and the pointer is unchanged.
- R9: When `wide_addr_i`=0, pointer and count arithmetic wraps at 16 bits and leaves the upper bits unchanged. When `wide_addr_i`=1, it wraps at 32 bits.
- R10: A request and its address stay asserted and unchanged until its acknowledge is seen, however many cycles that takes.
- R11: `done_o` is high for exactly one cycle per completed command.
- R12: A `start_i` pulse while `busy_o` is high is ignored: the running transfer, its addresses and its results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command start, accepted when idle |
| dir_out_i | input | 1 | 0: port to memory, 1: memory to port |
| rep_i | input | 1 | Repeat under count |
| size_i | input | 2 | Element size code |
| wide_addr_i | input | 1 | 1: 32-bit arithmetic, 0: 16-bit |
| flags_i | input | FW | Flags word, bit 10 is the direction flag |
| port_reg_i | input | 32 | Port register, low 16 bits used |
| ptr_i | input | AW | Initial pointer |
| count_i | input | AW | Initial count |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory acknowledge |
| io_req_o | output | 1 | Port request |
| io_we_o | output | 1 | Port write enable |
| io_addr_o | output | AW | Port access address |
| io_wdata_o | output | DW | Port write data |
| io_rdata_i | input | DW | Port read data, valid with ack |
| io_ack_i | input | 1 | Port acknowledge |
| xfer_size_o | output | 2 | Size code of current element |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | AW | Current pointer |
| count_o | output | AW | Current count |

## Verification
The bound checker watches, on every cycle, the properties that need only a short window of signal history. These are the quiet idle state, the rule that only one request is active at a time, requests held until acknowledge, the one-cycle completion pulse, the immediate finish on a zero count, and the fixed port address while a busy cycle sees a start. Some properties depend on the data across a whole command: the order of accesses, the data carried across them, the signed pointer step, the wrap at 16 bits with the upper bits kept, and the final count. A scoreboard can only show these by comparing each acknowledged access against the sequence predicted when the command is issued.

// File: rtl/strio_pkg.sv
package strio_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_STORE = 2'd2
   } strio_state_t;

   localparam int DF_BIT = 10;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/strio_step.sv
module strio_step #(
   parameter int AW = 32
) (
   input  logic [1:0]    size_code,
   input  logic          dir_down,
   output logic [AW-1:0] step
);
   import strio_pkg::*;

   logic [2:0] nbytes;

   always_comb begin
      case (size_code)
         SZ_BYTE: nbytes = 3'd1;
         SZ_HALF: nbytes = 3'd2;
         default: nbytes = 3'd4;
      endcase
   end

   assign step = dir_down ? (-AW'(nbytes)) : AW'(nbytes);
endmodule

// File: rtl/strio_wrap.sv
module strio_wrap #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] delta,
   input  logic          wide,
   output logic [AW-1:0] sum
);
   logic [15:0]   low16;
   logic [31:0]   low32;
   logic [AW-1:0] sum16;
   logic [AW-1:0] sum32;

   assign low16 = base[15:0] + delta[15:0];
   assign low32 = base[31:0] + delta[31:0];
   assign sum16 = {base[AW-1:16], low16};

   generate
      if (AW > 32) begin : g_upper
         logic unused_delta_hi;
         assign unused_delta_hi = ^delta[AW-1:32];
         assign sum32 = {base[AW-1:32], low32};
      end else begin : g_exact
         assign sum32 = low32;
      end
   endgenerate

   assign sum = wide ? sum32 : sum16;
endmodule

// File: rtl/strio_ctrl.sv
module strio_ctrl (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    start_zero,
   input  logic                    dir_out_q,
   input  logic                    last_elem,
   input  logic                    mem_ack_i,
   input  logic                    io_ack_i,
   output strio_pkg::strio_state_t state_o,
   output logic                    accept_o,
   output logic                    capture_o,
   output logic                    advance_o,
   output logic                    done_o
);
   import strio_pkg::*;

   strio_state_t state_q, state_d;
   logic         fin;
   logic         fetch_ack;
   logic         store_ack;

   assign fetch_ack = dir_out_q ? mem_ack_i : io_ack_i;
   assign store_ack = dir_out_q ? io_ack_i  : mem_ack_i;
   assign accept_o  = (state_q == ST_IDLE) && start_i;

   always_comb begin
      state_d   = state_q;
      capture_o = 1'b0;
      advance_o = 1'b0;
      fin       = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               if (start_zero) fin = 1'b1;
               else            state_d = ST_FETCH;
            end
         end
         ST_FETCH: begin
            if (fetch_ack) begin
               capture_o = 1'b1;
               state_d   = ST_STORE;
            end
         end
         ST_STORE: begin
            if (store_ack) begin
               advance_o = 1'b1;
               if (last_elem) begin
                  fin     = 1'b1;
                  state_d = ST_IDLE;
               end else begin
                  state_d = ST_FETCH;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_o  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_o  <= fin;
      end
   end

   assign state_o = state_q;
endmodule

// File: rtl/strio_seq.sv
module strio_seq #(
   parameter int              AW      = 32,
   parameter int              DW      = 32,
   parameter int              FW      = 32,
   parameter longint unsigned IO_BASE = 64'h8000_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          dir_out_i,
   input  logic          rep_i,
   input  logic [1:0]    size_i,
   input  logic          wide_addr_i,
   input  logic [FW-1:0] flags_i,
   input  logic [31:0]   port_reg_i,
   input  logic [AW-1:0] ptr_i,
   input  logic [AW-1:0] count_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_ack_i,
   output logic          io_req_o,
   output logic          io_we_o,
   output logic [AW-1:0] io_addr_o,
   output logic [DW-1:0] io_wdata_o,
   input  logic [DW-1:0] io_rdata_i,
   input  logic          io_ack_i,
   output logic [1:0]    xfer_size_o,
   output logic          busy_o,
   output logic          done_o,
   output logic [AW-1:0] ptr_o,
   output logic [AW-1:0] count_o
);
   import strio_pkg::*;

   localparam logic [AW-1:0] IO_BASE_W = AW'(IO_BASE);
   localparam logic [AW-1:0] DEC_ONE   = {AW{1'b1}};

   generate
      if (AW < 32) begin : g_bad_aw
         $error("strio_seq: AW must be at least 32");
      end
      if (DW < 32) begin : g_bad_dw
         $error("strio_seq: DW must hold a 4-byte element");
      end
      if (FW <= DF_BIT) begin : g_bad_fw
         $error("strio_seq: FW must include the direction flag bit");
      end
   endgenerate

   strio_state_t  state;
   logic          accept, capture, advance;
   logic          dir_out_q, rep_q, wide_q, down_q;
   logic [1:0]    size_q;
   logic [AW-1:0] ptr_q, cnt_q, io_addr_q;
   logic [DW-1:0] buf_q;
   logic [AW-1:0] step, ptr_nx, cnt_nx;
   logic          start_zero, last_elem;
   logic          in_fetch, in_store;
   logic          unused_bits;

   assign unused_bits = ^{flags_i[FW-1:DF_BIT+1], flags_i[DF_BIT-1:0], port_reg_i[31:16]};

   function automatic logic low_zero(input logic [AW-1:0] v, input logic wide);
      return wide ? (v[31:0] == 32'd0) : (v[15:0] == 16'd0);
   endfunction

   assign start_zero = rep_i && low_zero(count_i, wide_addr_i);
   assign last_elem  = !rep_q || low_zero(cnt_nx, wide_q);

   strio_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .start_zero (start_zero),
      .dir_out_q  (dir_out_q),
      .last_elem  (last_elem),
      .mem_ack_i  (mem_ack_i),
      .io_ack_i   (io_ack_i),
      .state_o    (state),
      .accept_o   (accept),
      .capture_o  (capture),
      .advance_o  (advance),
      .done_o     (done_o)
   );

   strio_step #(.AW(AW)) u_step (
      .size_code (size_q),
      .dir_down  (down_q),
      .step      (step)
   );

   strio_wrap #(.AW(AW)) u_ptr_wrap (
      .base  (ptr_q),
      .delta (step),
      .wide  (wide_q),
      .sum   (ptr_nx)
   );

   strio_wrap #(.AW(AW)) u_cnt_wrap (
      .base  (cnt_q),
      .delta (DEC_ONE),
      .wide  (wide_q),
      .sum   (cnt_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_out_q <= 1'b0;
         rep_q     <= 1'b0;
         wide_q    <= 1'b0;
         down_q    <= 1'b0;
         size_q    <= SZ_BYTE;
         ptr_q     <= '0;
         cnt_q     <= '0;
         io_addr_q <= IO_BASE_W;
         buf_q     <= '0;
      end else begin
         if (accept) begin
            dir_out_q <= dir_out_i;
            rep_q     <= rep_i;
            wide_q    <= wide_addr_i;
            down_q    <= flags_i[DF_BIT];
            size_q    <= size_i;
            ptr_q     <= ptr_i;
            cnt_q     <= count_i;
            io_addr_q <= IO_BASE_W + AW'(port_reg_i[15:0]);
         end
         if (capture) begin
            buf_q <= dir_out_q ? mem_rdata_i : io_rdata_i;
         end
         if (advance) begin
            ptr_q <= ptr_nx;
            if (rep_q) cnt_q <= cnt_nx;
         end
      end
   end

   assign in_fetch = (state == ST_FETCH);
   assign in_store = (state == ST_STORE);

   assign mem_req_o   = (in_fetch && dir_out_q) || (in_store && !dir_out_q);
   assign io_req_o    = (in_fetch && !dir_out_q) || (in_store && dir_out_q);
   assign mem_we_o    = in_store;
   assign io_we_o     = in_store;
   assign mem_addr_o  = ptr_q;
   assign io_addr_o   = io_addr_q;
   assign mem_wdata_o = buf_q;
   assign io_wdata_o  = buf_q;
   assign xfer_size_o = size_q;
   assign busy_o      = (state != ST_IDLE);
   assign ptr_o       = ptr_q;
   assign count_o     = cnt_q;
endmodule

// File: rtl/strio_seq_chk.sv
module strio_seq_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          rep_i,
   input logic          wide_addr_i,
   input logic [AW-1:0] count_i,
   input logic          mem_req_o,
   input logic          mem_we_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          mem_ack_i,
   input logic          io_req_o,
   input logic          io_we_o,
   input logic [AW-1:0] io_addr_o,
   input logic          io_ack_i,
   input logic          busy_o,
   input logic          done_o
);
   logic cnt_zero;
   assign cnt_zero = wide_addr_i ? (count_i[31:0] == 32'd0) : (count_i[15:0] == 16'd0);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!mem_req_o && !io_req_o));

   // R2 R3
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req_o && io_req_o));

   // R10
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   // R10
   io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req_o && !io_ack_i) |=> (io_req_o && $stable(io_addr_o) && $stable(io_we_o)));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   // R8
   zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && rep_i && cnt_zero) |=> (done_o && !busy_o));

   // R12
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> $stable(io_addr_o));
endmodule

bind strio_seq strio_seq_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .rep_i       (rep_i),
   .wide_addr_i (wide_addr_i),
   .count_i     (count_i),
   .mem_req_o   (mem_req_o),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_ack_i   (mem_ack_i),
   .io_req_o    (io_req_o),
   .io_we_o     (io_we_o),
   .io_addr_o   (io_addr_o),
   .io_ack_i    (io_ack_i),
   .busy_o      (busy_o),
   .done_o      (done_o)
);

// File: tb/strio_seq_tb.sv
`timescale 1ns/1ps
module strio_seq_tb;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [31:0] BASE = 32'h8000_0000;

   typedef struct packed {
      logic [1:0]  kind;   // 0 port read, 1 port write, 2 mem read, 3 mem write
      logic [31:0] addr;
      logic [31:0] data;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 0, dir_out_i = 0, rep_i = 0, wide_addr_i = 1;
   logic [1:0] size_i = 0;
   logic [31:0] flags_i = 0, port_reg_i = 0, ptr_i = 0, count_i = 0;
   logic mem_req_o, mem_we_o, io_req_o, io_we_o, busy_o, done_o;
   logic [AW-1:0] mem_addr_o, io_addr_o, ptr_o, count_o;
   logic [DW-1:0] mem_wdata_o, io_wdata_o;
   logic [DW-1:0] mem_rdata_i = 0, io_rdata_i = 0;
   logic mem_ack_i = 0, io_ack_i = 0;
   logic [1:0] xfer_size_o;

   item_t exp_q[$];
   int checks = 0, fails = 0, lat = 0, mem_wait = 0, io_wait = 0, io_k = 0, drv_k = 0;
   logic [1:0] cur_size = 0;
   string cur_req = "R2";
   bit finished = 0;

   always #2.5 clk = ~clk;

   strio_seq #(.AW(AW), .DW(DW), .IO_BASE(64'h8000_0000)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_out_i(dir_out_i), .rep_i(rep_i),
      .size_i(size_i), .wide_addr_i(wide_addr_i), .flags_i(flags_i), .port_reg_i(port_reg_i),
      .ptr_i(ptr_i), .count_i(count_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_ack_i(mem_ack_i), .io_req_o(io_req_o), .io_we_o(io_we_o), .io_addr_o(io_addr_o),
      .io_wdata_o(io_wdata_o), .io_rdata_i(io_rdata_i), .io_ack_i(io_ack_i),
      .xfer_size_o(xfer_size_o), .busy_o(busy_o), .done_o(done_o), .ptr_o(ptr_o),
      .count_o(count_o));

   function automatic logic [31:0] mem_val(input logic [31:0] a);
      return a ^ 32'h5A5A_A5A5;
   endfunction
   function automatic logic [31:0] io_pat(input int k);
      return 32'hC0DE_0000 | 32'(k);
   endfunction
   function automatic logic [31:0] wrap_add(input logic [31:0] a, input logic [31:0] d, input bit wide);
      logic [15:0] lo;
      lo = a[15:0] + d[15:0];
      return wide ? a + d : {a[31:16], lo};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic score(input logic [1:0] kind, input logic [31:0] addr, input logic [31:0] data);
      item_t e;
      if (exp_q.size() == 0) begin
         chk(0, cur_req, "unexpected access", addr, 32'h0);
      end else begin
         e = exp_q.pop_front();
         chk(kind == e.kind && addr == e.addr, cur_req, "access kind/addr",
             {kind, addr[29:0]}, {e.kind, e.addr[29:0]});
         if (kind[0]) chk(data == e.data, cur_req, "write data", data, e.data);
         chk(xfer_size_o == cur_size, "R4", "size code", 32'(xfer_size_o), 32'(cur_size));
      end
   endtask

   // memory responder / monitor
   always @(negedge clk) begin
      if (mem_ack_i) begin
         mem_ack_i = 0; mem_wait = 0;
      end else if (rst_n && mem_req_o) begin
         if (mem_wait >= lat) begin
            score(mem_we_o ? 2'd3 : 2'd2, mem_addr_o, mem_wdata_o);
            if (!mem_we_o) mem_rdata_i = mem_val(mem_addr_o);
            mem_ack_i = 1;
         end else mem_wait++;
      end
   end

   // port responder / monitor
   always @(negedge clk) begin
      if (io_ack_i) begin
         io_ack_i = 0; io_wait = 0;
      end else if (rst_n && io_req_o) begin
         if (io_wait >= lat) begin
            score(io_we_o ? 2'd1 : 2'd0, io_addr_o, io_wdata_o);
            if (!io_we_o) begin io_rdata_i = io_pat(io_k); io_k++; end
            io_ack_i = 1;
         end else io_wait++;
      end
   end

   task automatic run(input bit dout, input bit rep, input logic [1:0] sz, input bit wide,
                      input bit df, input logic [31:0] port, input logic [31:0] ptr,
                      input logic [31:0] cnt, input int latency, input bit poke, input string req);
      logic [31:0] p, step, ioa, exp_cnt;
      int n, waited;
      item_t it;
      step = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
      if (df) step = -step;
      ioa = BASE + {16'h0, port[15:0]};
      if (!rep) n = 1;
      else n = wide ? int'(cnt) : int'(cnt[15:0]);
      exp_cnt = rep ? (wide ? 32'h0 : {cnt[31:16], 16'h0}) : cnt;
      p = ptr;
      for (int i = 0; i < n; i++) begin
         if (!dout) begin
            it = '{2'd0, ioa, 32'h0};          exp_q.push_back(it);
            it = '{2'd3, p, io_pat(drv_k)};    exp_q.push_back(it);
            drv_k++;
         end else begin
            it = '{2'd2, p, 32'h0};            exp_q.push_back(it);
            it = '{2'd1, ioa, mem_val(p)};     exp_q.push_back(it);
         end
         p = wrap_add(p, step, wide);
      end
      lat = latency; cur_size = sz; cur_req = req;
      dir_out_i = dout; rep_i = rep; size_i = sz; wide_addr_i = wide;
      flags_i = df ? 32'h0000_0402 : 32'hFFFF_FBFF;
      port_reg_i = port; ptr_i = ptr; count_i = cnt;
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      waited = 0;
      if (n > 0) chk(busy_o == 1'b1, req, "busy after start", 32'(busy_o), 32'd1);
      while (!done_o && waited < 400) begin
         if (poke && waited == 2) begin
            start_i = 1; dir_out_i = ~dout; port_reg_i = 32'h0000_0BAD;
            ptr_i = 32'hDEAD_0000; count_i = 32'd9; size_i = 2'd0;
         end
         if (poke && waited == 3) start_i = 0;
         @(negedge clk);
         waited++;
      end
      start_i = 0;
      chk(done_o == 1'b1, req, "done seen", 32'(done_o), 32'd1);
      if (n == 0) chk(waited == 0, "R8", "cycles to done", 32'(waited), 32'd0);
      chk(ptr_o == p, req, "final pointer", ptr_o, p);
      chk(count_o == exp_cnt, req, "final count", count_o, exp_cnt);
      chk(exp_q.size() == 0, req, "accesses outstanding", 32'(exp_q.size()), 32'd0);
      chk(busy_o == 1'b0, req, "idle at done", 32'(busy_o), 32'd0);
      @(negedge clk);
      chk(done_o == 1'b0, "R11", "done one cycle", 32'(done_o), 32'd0);
      exp_q.delete();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "R1", "watchdog expired", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(busy_o == 0 && done_o == 0, "R1", "busy/done after reset", {busy_o, done_o}, 32'd0);
      chk(mem_req_o == 0 && io_req_o == 0, "R1", "requests after reset", {mem_req_o, io_req_o}, 32'd0);
      // R2 R5 R6: single port-to-memory byte, upward
      run(0, 0, 2'd0, 1, 0, 32'hABCD_0060, 32'h0000_1000, 32'd7, 0, 0, "R6");
      // R3 R4: single memory-to-port word, downward
      run(1, 0, 2'd2, 1, 1, 32'h0000_03F8, 32'h0000_2000, 32'd5, 1, 0, "R4");
      // R7: repeated halves upward, slow acks (R10)
      run(0, 1, 2'd1, 1, 0, 32'h0000_0071, 32'h0000_3000, 32'd4, 3, 0, "R7");
      run(1, 1, 2'd3, 1, 1, 32'h1111_2222, 32'h0000_4010, 32'd3, 2, 0, "R10");
      // R8: zero counts, including upper-bit count in 16-bit mode
      run(0, 1, 2'd2, 1, 0, 32'h0000_0010, 32'h0000_5000, 32'd0, 0, 0, "R8");
      run(1, 1, 2'd0, 0, 0, 32'h0000_0010, 32'h0000_5000, 32'h0005_0000, 0, 0, "R8");
      // R9: 16-bit wrap with upper bits kept
      run(0, 1, 2'd2, 0, 0, 32'h0000_0020, 32'h1234_FFF8, 32'h0009_0003, 1, 0, "R9");
      run(1, 0, 2'd1, 0, 1, 32'h0000_0022, 32'h0000_0000, 32'd1, 0, 0, "R9");
      // R12: start pulsed while busy
      run(1, 1, 2'd1, 1, 0, 32'h0000_0040, 32'h0000_6000, 32'd3, 2, 1, "R12");
      finish_run();
   end
endmodule